// File: doc/BRIEF.md
# Center-Aligned Three-Phase Motor PWM Generator

This block drives the six gate signals of a three-phase inverter bridge, plus one single-ended auxiliary output. A shared triangular carrier counts from zero up to the period value and back to zero. Each phase compares its duty value against this carrier to get a raw on/off level. A dead-band stage then turns that level into a complementary high-side/low-side pair. The stage delays every turn-on by a programmable number of clock cycles and applies every turn-off at once.

Period, phase duties and auxiliary duty are written into shadow inputs. They move to the active registers only at a reload point. The reload point can be every half period (the top and the bottom of the carrier), every full period (the bottom), or every Nth full period. The cycle in which new active values take effect is marked by a one-cycle pulse. This pulse is both the control-loop interrupt and the synchronization strobe for other blocks. The carrier value and its direction are also exported for the same purpose.

A fault input forces every output low through gates only, with no register in the path. A latched fault flag keeps the outputs off until software clears it while the fault input is inactive.

Top module: `mc_pwm_gen`

## Requirements
- R1: After reset the carrier reads 0 in its descending state. It then steps by one per clock in the sequence 0,1,...,P,P-1,...,1,0, where P is the active period (P >= 1). One carrier period is therefore 2P cycles. `cnt_dn` is 0 while the value is 1..P on the way up, and 1 otherwise.
- R2: For an active duty d with 0 < d < P, the raw level of a phase is on for exactly 2d contiguous cycles per carrier period. The block is centred on the carrier bottom.
- R3: A duty of 0 keeps the raw level off for the whole period, and a duty >= P keeps it on for the whole period. In both cases there is no pulse of any length, with any dead time.
- R4: With dead time T, each rising edge of a high-side or low-side output comes T cycles after the matching raw edge. Each falling edge is not delayed. A raw pulse of T cycles or fewer produces no output pulse. For 0 < d < P this gives high-side on-time max(2d-T,0) and low-side on-time max(2P-2d-T,0) per period.
- R5: The high-side and low-side outputs of one phase are never on in the same cycle.
- R6: The auxiliary output uses the same compare rule with no dead time. Its on-time per period is 0 for duty 0, 2P for duty >= P, and 2d otherwise.
- R7: Changes to the shadow inputs have no effect on outputs or carrier timing until the next reload point.
- R8: `rld_mode` selects the reload point: 0 gives each carrier top and bottom (pulse spacing P), 1 gives each bottom (2P), and 2 gives every Nth bottom with N = `rld_n` (2PN; N = 0 acts as 1).
- R9: `cycle_irq` is a one-cycle pulse in the first cycle that uses the newly loaded values. For a load at the bottom, the carrier then reads 1 and is ascending.
- R10: While `fault_in` is 1, all seven outputs are 0 at once, without waiting for a clock edge.
- R11: A fault sets `fault_flag`. The flag and the output blanking stay set until `fault_clr` is sampled high while `fault_in` is low. A clear request while the fault is still present is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_sh | input | CNT_W | Shadow carrier peak value P |
| duty_sh | input | NPH*CNT_W | Shadow duties, phase i at bits [i*CNT_W +: CNT_W] |
| aux_duty_sh | input | CNT_W | Shadow duty of the auxiliary channel |
| dead_time | input | DT_W | Turn-on delay in clock cycles |
| rld_mode | input | 2 | Reload point select (0 half, 1 full, 2 every Nth period) |
| rld_n | input | NDIV_W | Period count N for mode 2 |
| fault_in | input | 1 | Fault request, active high |
| fault_clr | input | 1 | Clear request for the latched fault |
| pwm_hi | output | NPH | High-side gate outputs |
| pwm_lo | output | NPH | Low-side gate outputs |
| pwm_aux | output | 1 | Auxiliary single-ended output |
| fault_flag | output | 1 | Latched fault state |
| cnt_val | output | CNT_W | Carrier value |
| cnt_dn | output | 1 | Carrier direction, 1 = descending |
| cycle_irq | output | 1 | Reload pulse / control-loop interrupt |

## Verification
The bench sweeps every duty from 0 to P+1 against several dead times and two periods. It measures per-period on-times, which exposes off-by-one compare rules (2d-1 instead of 2d) and a single-cycle glitch at 0% or 100%. A dead-band stage that delays turn-off, or that fails to swallow short pulses, gives on-times that do not match max(2d-T,0). Reload spacing is timed in all three modes, including N = 0, to catch a divider that loads one period early or never. A period change made just after a reload must leave the current interval intact, or the shadow path is leaking. For the fault path, the bench checks that blanking appears between clock edges, and that a clear request arriving while the fault is still present is ignored.

// File: rtl/mc_pwm_pkg.sv
`timescale 1ns/1ps
package mc_pwm_pkg;
  typedef enum logic [1:0] {
    RLD_HALF = 2'd0,
    RLD_FULL = 2'd1,
    RLD_NTH  = 2'd2
  } rld_mode_e;
endpackage

// File: rtl/mc_pwm_carrier.sv
`timescale 1ns/1ps
module mc_pwm_carrier
  import mc_pwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NDIV_W = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  per_act,
  input  logic [1:0]        rld_mode,
  input  logic [NDIV_W-1:0] rld_n,
  output logic [CNT_W-1:0]  cnt,
  output logic              cnt_dn,
  output logic              at_top,
  output logic              at_bot,
  output logic              load
);
  rld_mode_e         mode;
  logic [NDIV_W-1:0] nth_q;

  assign mode   = rld_mode_e'(rld_mode);
  assign at_bot = cnt_dn && (cnt == '0);
  assign at_top = !cnt_dn && (cnt >= per_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      cnt_dn <= 1'b1;
    end else if (cnt_dn) begin
      if (cnt == '0) begin
        cnt_dn <= 1'b0;
        cnt    <= CNT_W'(1);
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (at_top) begin
      cnt_dn <= 1'b1;
      cnt    <= cnt - 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // period divider for the every-Nth mode; zero at reset so the first bottom loads
  always_ff @(posedge clk) begin
    if (rst)
      nth_q <= '0;
    else if (at_bot)
      nth_q <= (nth_q == '0) ? ((rld_n == '0) ? '0 : rld_n - 1'b1) : nth_q - 1'b1;
  end

  always_comb begin
    load = 1'b0;
    if (mode == RLD_HALF)      load = at_bot || at_top;
    else if (mode == RLD_FULL) load = at_bot;
    else                       load = at_bot && (nth_q == '0);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!cnt_dn && !at_top) |=> (cnt == $past(cnt) + CNT_W'(1)));  // R1
  AST_BOTTOM_TURN: assert property (@(posedge clk) disable iff (rst)
    at_bot |=> (!cnt_dn && cnt == CNT_W'(1)));  // R1
endmodule

// File: rtl/mc_pwm_deadband.sv
`timescale 1ns/1ps
module mc_pwm_deadband #(
  parameter int DT_W = 4
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            raw,
  input  logic [DT_W-1:0] dt,
  output logic            hi,
  output logic            lo
);
  logic            raw_q;
  logic [DT_W-1:0] dtc, dtc_n;

  // every raw edge restarts the guard count; both sides stay off until it expires
  always_comb begin
    if (raw != raw_q)     dtc_n = dt;
    else if (dtc != '0)   dtc_n = dtc - 1'b1;
    else                  dtc_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
      dtc   <= '0;
      hi    <= 1'b0;
      lo    <= 1'b0;
    end else begin
      raw_q <= raw;
      dtc   <= dtc_n;
      hi    <= raw && (dtc_n == '0);
      lo    <= !raw && (dtc_n == '0);
    end
  end

  AST_HI_GAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(hi) && $past(!rst) && $past(dt) != '0) |-> !$past(lo));  // R4
  AST_LO_GAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(lo) && $past(!rst) && $past(dt) != '0) |-> !$past(hi));  // R4
endmodule

// File: rtl/mc_pwm_gen.sv
`timescale 1ns/1ps
module mc_pwm_gen #(
  parameter int CNT_W  = 8,
  parameter int DT_W   = 4,
  parameter int NDIV_W = 4,
  parameter int NPH    = 3
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CNT_W-1:0]      period_sh,
  input  logic [NPH*CNT_W-1:0]  duty_sh,
  input  logic [CNT_W-1:0]      aux_duty_sh,
  input  logic [DT_W-1:0]       dead_time,
  input  logic [1:0]            rld_mode,
  input  logic [NDIV_W-1:0]     rld_n,
  input  logic                  fault_in,
  input  logic                  fault_clr,
  output logic [NPH-1:0]        pwm_hi,
  output logic [NPH-1:0]        pwm_lo,
  output logic                  pwm_aux,
  output logic                  fault_flag,
  output logic [CNT_W-1:0]      cnt_val,
  output logic                  cnt_dn,
  output logic                  cycle_irq
);
  localparam int DUTY_W = NPH * CNT_W;

  logic [CNT_W-1:0]          per_act;
  logic [NPH-1:0][CNT_W-1:0] duty_act;
  logic [CNT_W-1:0]          aux_act;
  logic                      at_top, at_bot, load;
  logic                      irq_q, aux_q, fault_q, kill;
  logic [NPH-1:0]            raw, hi_q, lo_q;

  function automatic logic cmp_on(input logic [CNT_W-1:0] d, input logic [CNT_W-1:0] c,
                                  input logic dn, input logic [CNT_W-1:0] p);
    if (d == '0)      return 1'b0;
    else if (d >= p)  return 1'b1;
    else if (dn)      return c <= d;
    else              return c < d;
  endfunction

  mc_pwm_carrier #(.CNT_W(CNT_W), .NDIV_W(NDIV_W)) u_carrier (
    .clk(clk), .rst(rst), .per_act(per_act), .rld_mode(rld_mode), .rld_n(rld_n),
    .cnt(cnt_val), .cnt_dn(cnt_dn), .at_top(at_top), .at_bot(at_bot), .load(load)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      per_act  <= '0;
      duty_act <= '0;
      aux_act  <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= load;
      if (load) begin
        per_act  <= period_sh;
        duty_act <= DUTY_W'(duty_sh);
        aux_act  <= aux_duty_sh;
      end
    end
  end

  generate
    for (genvar i = 0; i < NPH; i++) begin : g_phase
      assign raw[i] = cmp_on(duty_act[i], cnt_val, cnt_dn, per_act);
      mc_pwm_deadband #(.DT_W(DT_W)) u_db (
        .clk(clk), .rst(rst), .raw(raw[i]), .dt(dead_time),
        .hi(hi_q[i]), .lo(lo_q[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) aux_q <= 1'b0;
    else     aux_q <= cmp_on(aux_act, cnt_val, cnt_dn, per_act);
  end

  always_ff @(posedge clk) begin
    if (rst)            fault_q <= 1'b0;
    else if (fault_in)  fault_q <= 1'b1;
    else if (fault_clr) fault_q <= 1'b0;
  end

  // gate-only blanking path so the fault acts even without clock edges
  assign kill       = fault_in | fault_q;
  assign pwm_hi     = hi_q & {NPH{~kill}};
  assign pwm_lo     = lo_q & {NPH{~kill}};
  assign pwm_aux    = aux_q & ~kill;
  assign fault_flag = fault_q;
  assign cycle_irq  = irq_q;

  AST_FAULT_SET: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fault_in)) |-> fault_flag);  // R11
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(fault_flag) && !$past(fault_clr)) |-> fault_flag);  // R11
  AST_RELOAD_POINT: assert property (@(posedge clk) disable iff (rst)
    cycle_irq |-> $past(cnt_val == '0 || (!cnt_dn && cnt_val >= per_act)));  // R9
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cycle_irq |-> ($stable(duty_act) && $stable(per_act)));  // R7
endmodule

// File: tb/mc_pwm_gen_tb.sv
`timescale 1ns/1ps
module mc_pwm_gen_tb;
  localparam int CNT_W = 8, DT_W = 4, NDIV_W = 4, NPH = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [CNT_W-1:0] period_sh = 8'd4, aux_duty_sh = '0;
  logic [NPH*CNT_W-1:0] duty_sh = '0;
  logic [DT_W-1:0] dead_time = '0;
  logic [1:0] rld_mode = 2'd1;
  logic [NDIV_W-1:0] rld_n = '0;
  logic fault_in = 1'b0, fault_clr = 1'b0;
  logic [NPH-1:0] pwm_hi, pwm_lo;
  logic pwm_aux, fault_flag, cnt_dn, cycle_irq;
  logic [CNT_W-1:0] cnt_val;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mc_pwm_gen #(.CNT_W(CNT_W), .DT_W(DT_W), .NDIV_W(NDIV_W), .NPH(NPH)) u_dut (
    .clk(clk), .rst(rst), .period_sh(period_sh), .duty_sh(duty_sh),
    .aux_duty_sh(aux_duty_sh), .dead_time(dead_time), .rld_mode(rld_mode),
    .rld_n(rld_n), .fault_in(fault_in), .fault_clr(fault_clr),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .pwm_aux(pwm_aux), .fault_flag(fault_flag),
    .cnt_val(cnt_val), .cnt_dn(cnt_dn), .cycle_irq(cycle_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mx0(input int v);
    return (v < 0) ? 0 : v;
  endfunction
  function automatic int exp_hi(input int d, input int p, input int t);
    if (d == 0) return 0;
    if (d >= p) return 2 * p;
    return mx0(2 * d - t);
  endfunction
  function automatic int exp_lo(input int d, input int p, input int t);
    if (d == 0) return 2 * p;
    if (d >= p) return 0;
    return mx0(2 * p - 2 * d - t);
  endfunction
  function automatic int exp_aux(input int d, input int p);
    if (d == 0) return 0;
    if (d >= p) return 2 * p;
    return 2 * d;
  endfunction

  task automatic wait_irq();
    do @(negedge clk); while (!cycle_irq);
  endtask

  task automatic irq_gap(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!cycle_irq && gap < 2000);
  endtask

  task automatic sweep_point(input int p, input int t, input int d);
    int dv[NPH];
    int hc[NPH], lc[NPH], ov[NPH];
    int ac;
    dv[0] = d; dv[1] = p + 1 - d; dv[2] = d / 2;
    for (int i = 0; i < NPH; i++) duty_sh[i*CNT_W +: CNT_W] = CNT_W'(dv[i]);
    aux_duty_sh = CNT_W'(p + 1 - d);
    period_sh = CNT_W'(p);
    dead_time = DT_W'(t);
    wait_irq(); wait_irq(); wait_irq();
    ac = 0;
    for (int i = 0; i < NPH; i++) begin hc[i] = 0; lc[i] = 0; ov[i] = 0; end
    for (int k = 0; k < 2 * p; k++) begin
      for (int i = 0; i < NPH; i++) begin
        hc[i] += int'(pwm_hi[i]);
        lc[i] += int'(pwm_lo[i]);
        ov[i] += int'(pwm_hi[i] & pwm_lo[i]);
      end
      ac += int'(pwm_aux);
      @(negedge clk);
    end
    for (int i = 0; i < NPH; i++) begin
      chk(hc[i] == exp_hi(dv[i], p, t), (dv[i] == 0 || dv[i] >= p) ? "R3 hi" : "R2/R4 hi",
          hc[i], exp_hi(dv[i], p, t));
      chk(lc[i] == exp_lo(dv[i], p, t), (dv[i] == 0 || dv[i] >= p) ? "R3 lo" : "R4 lo",
          lc[i], exp_lo(dv[i], p, t));
      chk(ov[i] == 0, "R5 overlap", ov[i], 0);
    end
    chk(ac == exp_aux(p + 1 - d, p), "R6 aux", ac, exp_aux(p + 1 - d, p));
  endtask

  task automatic carrier_check(input int p);
    int bad;
    bad = 0;
    period_sh = CNT_W'(p);
    wait_irq(); wait_irq();
    chk(cnt_val == CNT_W'(1) && !cnt_dn, "R9 value at reload", int'(cnt_val), 1);
    for (int k = 0; k < 2 * p; k++) begin
      int c, ev;
      bit edn;
      c = (k + 1) % (2 * p);
      ev = (c <= p) ? c : 2 * p - c;
      edn = !(c >= 1 && c <= p);
      if (int'(cnt_val) != ev || cnt_dn != edn) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R1 carrier sequence", bad, 0);
  endtask

  initial begin
    int gap;
    repeat (4) @(negedge clk);
    chk(pwm_hi == '0 && pwm_lo == '0 && !pwm_aux, "R1 reset outputs", int'(pwm_hi | pwm_lo), 0);
    chk(cnt_val == '0 && cnt_dn, "R1 reset carrier", int'(cnt_val), 0);
    chk(!cycle_irq && !fault_flag, "R1 reset flags", int'(cycle_irq), 0);
    rst = 1'b0;

    // R1 / R9: carrier shape in full-period mode
    rld_mode = 2'd1;
    carrier_check(4);
    carrier_check(7);

    // R2..R6: duty x dead time sweep
    rld_mode = 2'd1;
    for (int pi = 0; pi < 2; pi++)
      for (int ti = 0; ti < 3; ti++)
        for (int d = 0; d <= ((pi == 0) ? 4 : 6) + 1; d++)
          sweep_point((pi == 0) ? 4 : 6, (ti == 0) ? 0 : ((ti == 1) ? 1 : 3), d);

    // R8: reload spacing in each mode
    period_sh = 8'd5; dead_time = '0;
    rld_mode = 2'd0;
    wait_irq(); wait_irq(); irq_gap(gap);
    chk(gap == 5, "R8 half-period spacing", gap, 5);
    rld_mode = 2'd1;
    wait_irq(); wait_irq(); irq_gap(gap);
    chk(gap == 10, "R8 full-period spacing", gap, 10);
    rld_mode = 2'd2; rld_n = 4'd3;
    repeat (3) wait_irq();
    irq_gap(gap);
    chk(gap == 30, "R8 every-3rd spacing", gap, 30);
    rld_n = 4'd0;
    repeat (3) wait_irq();
    irq_gap(gap);
    chk(gap == 10, "R8 N=0 acts as 1", gap, 10);

    // R7: period change after a reload keeps the running interval
    rld_mode = 2'd1; period_sh = 8'd5;
    wait_irq(); wait_irq();
    period_sh = 8'd7;
    irq_gap(gap);
    chk(gap == 10, "R7 old period until reload", gap, 10);
    irq_gap(gap);
    chk(gap == 14, "R7 new period after reload", gap, 14);

    // R7: duty shadow ignored mid-interval (every-3rd mode)
    period_sh = 8'd4; duty_sh = '0; duty_sh[0 +: CNT_W] = 8'd2;
    rld_mode = 2'd2; rld_n = 4'd3;
    repeat (3) wait_irq();
    duty_sh[0 +: CNT_W] = 8'd0;
    begin
      int hc;
      hc = 0;
      for (int k = 0; k < 16; k++) begin @(negedge clk); hc += int'(pwm_hi[0]); end
      chk(hc == 8, "R7 duty shadow not applied early", hc, 8);
    end

    // R10 / R11: fault blanking and latch
    rld_mode = 2'd1; duty_sh = '0; aux_duty_sh = 8'd4; period_sh = 8'd4;
    repeat (3) wait_irq();
    chk(pwm_lo == 3'b111 && pwm_aux, "R10 pre-fault outputs on", int'(pwm_lo), 7);
    #1 fault_in = 1'b1;
    #0.5;
    chk(pwm_lo == '0 && pwm_hi == '0 && !pwm_aux, "R10 immediate blanking", int'(pwm_lo), 0);
    @(negedge clk); @(negedge clk);
    chk(fault_flag, "R11 flag set", int'(fault_flag), 1);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    chk(fault_flag && pwm_lo == '0, "R11 clear ignored while fault present", int'(fault_flag), 1);
    fault_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(fault_flag && pwm_lo == '0 && !pwm_aux, "R11 blanking held after fault drops",
        int'(pwm_lo), 0);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    chk(!fault_flag, "R11 flag cleared", int'(fault_flag), 0);
    chk(pwm_lo == 3'b111 && pwm_aux, "R11 outputs resume", int'(pwm_lo), 7);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule